// File: doc/BRIEF.md
# Profiling Record Filter

This block sits at the end of a statistical profiling pipeline and decides, for each completed sample record, whether it is written out or thrown away. A record arrives as a one-cycle strobe carrying its operation class, a 12-bit vector of events seen while the operation was in flight, and its latency, counted from the moment sampling began rather than from the start of execution.

Three filters must agree before a record is kept.

- **Type filter:** the operation class must match one of the enabled classes.
- **Event filter:** every event required by the mask must be present.
- **Latency filter:** the latency must reach the minimum threshold.

A separate discard mode rejects every record. The per-event counters still see every record in this mode, so event statistics can be gathered without producing any output. Running totals of kept and discarded records are kept next to the per-event counters.

Top module: `rec_filter`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and low otherwise.
- R2: Class encoding is 0 other, 1 load, 2 store, 3 branch. With no class enable set, every class passes. With one or more enables set, a record passes only if its class matches an enabled one, so class 0 then never passes.
- R3: The event filter only looks at mask bits 1 (retired), 3 (L1D refill), 5 (TLB refill), 7 (mispredict) and 11 (misaligned); all other mask bits are ignored. A record passes only when every such mask bit is also set in its event vector. For example, mask 0x002 keeps only retired operations and mask 0x080 keeps only mispredicts.
- R4: A record whose latency is below `lat_min` is rejected. A latency equal to the threshold passes. A threshold of 0 passes every latency.
- R5: `out_keep` is high only when the type, event and latency filters all pass in the same record.
- R6: While `drop_all` is high, `out_keep` stays low for every record, and the record is counted as discarded.
- R7: `kept_cnt` or `drop_cnt` rises by exactly one per record, in the cycle `out_valid` is high, matching `out_keep`. Both counters stay unchanged when there is no record.
- R8: Slot i of `evt_cnt` (bits i*CNTW and up) counts records having event bit 1, 3, 5, 7 or 11 for i = 0 to 4. It counts every record, whatever the filter decision and whether or not discard mode is on.
- R9: During and after reset, `out_valid`, `out_keep` and every counter are zero.
- R10: `out_keep` is never high while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Record present this cycle |
| in_class | input | 2 | Operation class (0 other, 1 load, 2 store, 3 branch) |
| in_events | input | EVW | Event vector of the record |
| in_latency | input | LATW | Latency from start of sampling |
| en_load | input | 1 | Pass load records |
| en_store | input | 1 | Pass store records |
| en_branch | input | 1 | Pass branch records |
| evt_mask | input | EVW | Required events |
| lat_min | input | LATW | Minimum latency, 0 disables |
| drop_all | input | 1 | Discard mode |
| out_valid | output | 1 | Decision strobe |
| out_keep | output | 1 | 1 keep, 0 discard |
| kept_cnt | output | CNTW | Records kept |
| drop_cnt | output | CNTW | Records discarded |
| evt_cnt | output | 5*CNTW | Per-event record counts |

## Verification
The assertions assume that the control inputs (`en_load`, `en_store`, `en_branch`, `evt_mask`, `lat_min` and `drop_all`) hold steady between a record strobe and its decision. They also assume the counters never wrap during a run. The stimulus applies each control set together with its record on a falling edge. It issues far fewer records than the 16-bit counters can hold, and it asserts reset only when no record is in flight.

// File: rtl/rec_filter.sv
module rec_filter #(
  parameter int EVW  = 12,
  parameter int LATW = 16,
  parameter int CNTW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           in_class,
  input  logic [EVW-1:0]       in_events,
  input  logic [LATW-1:0]      in_latency,
  input  logic                 en_load,
  input  logic                 en_store,
  input  logic                 en_branch,
  input  logic [EVW-1:0]       evt_mask,
  input  logic [LATW-1:0]      lat_min,
  input  logic                 drop_all,
  output logic                 out_valid,
  output logic                 out_keep,
  output logic [CNTW-1:0]      kept_cnt,
  output logic [CNTW-1:0]      drop_cnt,
  output logic [5*CNTW-1:0]    evt_cnt
);

  localparam int NEV = 5;

  function automatic int ev_pos(input int i);
    return (i < 4) ? (2 * i + 1) : 11;
  endfunction

  function automatic logic [EVW-1:0] filt_bits();
    logic [EVW-1:0] m;
    m = '0;
    for (int i = 0; i < NEV; i++) m[ev_pos(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [EVW-1:0] FILT = filt_bits();

  logic any_en, type_ok, evt_ok, lat_ok, keep_d;
  logic [EVW-1:0] need;

  assign any_en  = en_load | en_store | en_branch;
  assign type_ok = !any_en
                 | (en_load   && in_class == 2'd1)
                 | (en_store  && in_class == 2'd2)
                 | (en_branch && in_class == 2'd3);
  assign need    = evt_mask & FILT;
  assign evt_ok  = (in_events & need) == need;
  assign lat_ok  = in_latency >= lat_min;
  assign keep_d  = type_ok && evt_ok && lat_ok && !drop_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_keep  <= 1'b0;
      kept_cnt  <= '0;
      drop_cnt  <= '0;
    end else begin
      out_valid <= in_valid;
      out_keep  <= in_valid && keep_d;
      if (in_valid) begin
        if (keep_d) kept_cnt <= kept_cnt + 1'b1;
        else        drop_cnt <= drop_cnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NEV; g++) begin : g_evc
    logic [CNTW-1:0] c;
    always_ff @(posedge clk) begin
      if (!rst_n)                          c <= '0;
      else if (in_valid && in_events[ev_pos(g)]) c <= c + 1'b1;
    end
    assign evt_cnt[g*CNTW +: CNTW] = c;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);                                             // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);                                           // R1
  AST_KEEP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_keep |-> out_valid);                                             // R10
  AST_DROP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && drop_all) |=> !out_keep);                               // R6
  AST_SLOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_latency < lat_min) |=> !out_keep);                   // R4
  AST_OTHER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && any_en && in_class == 2'd0) |=> !out_keep);             // R2
  AST_ONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (kept_cnt + drop_cnt) == $past(kept_cnt + drop_cnt) + 1'b1); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(kept_cnt) && $stable(drop_cnt) && $stable(evt_cnt))); // R7

endmodule

// File: tb/test_rec_filter.sv
module test_rec_filter;
  localparam int EVW = 12, LATW = 16, CNTW = 16;
  localparam int VW = 2 + 12 + 16 + 3 + 12 + 16 + 1 + 1;
  localparam int NV = 20;
  localparam logic [VW-1:0] VEC [0:NV-1] = '{
    // class, events, latency, {ld,st,br}, mask, min, drop, expected keep
    {2'd1, 12'h000, 16'd5,  3'b000, 12'h000, 16'd0,  1'b0, 1'b1}, // R2 none enabled
    {2'd0, 12'h000, 16'd5,  3'b100, 12'h000, 16'd0,  1'b0, 1'b0}, // R2 other blocked
    {2'd1, 12'h000, 16'd5,  3'b100, 12'h000, 16'd0,  1'b0, 1'b1}, // R2 load
    {2'd2, 12'h000, 16'd5,  3'b101, 12'h000, 16'd0,  1'b0, 1'b0}, // R2 store not enabled
    {2'd3, 12'h000, 16'd5,  3'b101, 12'h000, 16'd0,  1'b0, 1'b1}, // R2 branch OR
    {2'd2, 12'h000, 16'd5,  3'b010, 12'h000, 16'd0,  1'b0, 1'b1}, // R2 store
    {2'd0, 12'h000, 16'd5,  3'b000, 12'h000, 16'd0,  1'b0, 1'b1}, // R2 other passes
    {2'd1, 12'h002, 16'd5,  3'b000, 12'h002, 16'd0,  1'b0, 1'b1}, // R3 retired
    {2'd1, 12'h080, 16'd5,  3'b000, 12'h002, 16'd0,  1'b0, 1'b0}, // R3 missing retired
    {2'd3, 12'h0A0, 16'd5,  3'b000, 12'h0A0, 16'd0,  1'b0, 1'b1}, // R3 all required
    {2'd3, 12'h080, 16'd5,  3'b000, 12'h0A0, 16'd0,  1'b0, 1'b0}, // R3 one missing
    {2'd1, 12'h000, 16'd5,  3'b000, 12'h755, 16'd0,  1'b0, 1'b1}, // R3 ignored bits
    {2'd1, 12'h8AA, 16'd5,  3'b000, 12'hFFF, 16'd0,  1'b0, 1'b1}, // R3 full mask
    {2'd1, 12'h000, 16'd9,  3'b000, 12'h000, 16'd10, 1'b0, 1'b0}, // R4 below
    {2'd1, 12'h000, 16'd10, 3'b000, 12'h000, 16'd10, 1'b0, 1'b1}, // R4 equal
    {2'd1, 12'h000, 16'd0,  3'b000, 12'h000, 16'd0,  1'b0, 1'b1}, // R4 zero threshold
    {2'd3, 12'h082, 16'd20, 3'b001, 12'h082, 16'd10, 1'b0, 1'b1}, // R5 all pass
    {2'd3, 12'h082, 16'd5,  3'b001, 12'h082, 16'd10, 1'b0, 1'b0}, // R5 latency fails
    {2'd1, 12'h082, 16'd20, 3'b001, 12'h082, 16'd10, 1'b0, 1'b0}, // R5 type fails
    {2'd3, 12'h8AA, 16'd20, 3'b000, 12'h000, 16'd0,  1'b1, 1'b0}  // R6 drop mode
  };

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] in_class = 0;
  logic [EVW-1:0] in_events = 0, evt_mask = 0;
  logic [LATW-1:0] in_latency = 0, lat_min = 0;
  logic en_load = 0, en_store = 0, en_branch = 0, drop_all = 0;
  logic out_valid, out_keep;
  logic [CNTW-1:0] kept_cnt, drop_cnt;
  logic [5*CNTW-1:0] evt_cnt;

  int checks = 0, errors = 0, kx = 0, dx = 0;
  int evx [5] = '{0, 0, 0, 0, 0};
  int pos [5] = '{1, 3, 5, 7, 11};
  bit done = 0;

  always #10 clk = ~clk;

  rec_filter #(.EVW(EVW), .LATW(LATW), .CNTW(CNTW)) i_rec_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_events(in_events), .in_latency(in_latency), .en_load(en_load),
    .en_store(en_store), .en_branch(en_branch), .evt_mask(evt_mask),
    .lat_min(lat_min), .drop_all(drop_all), .out_valid(out_valid),
    .out_keep(out_keep), .kept_cnt(kept_cnt), .drop_cnt(drop_cnt),
    .evt_cnt(evt_cnt));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_counts(input string req);
    chk(kept_cnt == CNTW'(kx), {req, " R7 kept_cnt"}, int'(kept_cnt), kx);
    chk(drop_cnt == CNTW'(dx), {req, " R7 drop_cnt"}, int'(drop_cnt), dx);
    for (int i = 0; i < 5; i++)
      chk(evt_cnt[i*CNTW +: CNTW] == CNTW'(evx[i]), {req, " R8 evt_cnt"},
          int'(evt_cnt[i*CNTW +: CNTW]), evx[i]);
  endtask

  task automatic record(input logic [VW-1:0] v, input string req);
    bit exp;
    {in_class, in_events, in_latency, en_load, en_store, en_branch,
     evt_mask, lat_min, drop_all, exp} = v;
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    if (exp) kx++; else dx++;
    for (int i = 0; i < 5; i++) if (in_events[pos[i]]) evx[i]++;
    chk(out_valid === 1'b1, {req, " R1 out_valid"}, int'(out_valid), 1);
    chk(out_keep === exp, {req, " out_keep"}, int'(out_keep), int'(exp));
    check_counts(req);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
    chk(out_keep === 1'b0, "R9 out_keep in reset", int'(out_keep), 0);
    check_counts("R9 reset");
    rst_n = 1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 idle", int'(out_valid), 0);

    for (int n = 0; n < NV; n++) begin
      record(VEC[n], $sformatf("vec%0d", n));
      @(negedge clk);
      chk(out_valid === 1'b0, "R1 no strobe after idle", int'(out_valid), 0);
      chk(out_keep === 1'b0, "R10 keep low when idle", int'(out_keep), 0);
      check_counts("R7 idle hold");
    end

    // back-to-back records, the second inside discard mode
    record({2'd1, 12'h8AA, 16'd3, 3'b000, 12'h000, 16'd0, 1'b0, 1'b1}, "R1 b2b first");
    record({2'd1, 12'h8AA, 16'd3, 3'b000, 12'h000, 16'd0, 1'b1, 1'b0}, "R6 b2b second");
    record({2'd2, 12'h808, 16'd3, 3'b010, 12'h008, 16'd0, 1'b0, 1'b1}, "R3 b2b third");
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 strobe ends", int'(out_valid), 0);

    // reset in the middle of a run clears everything
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    kx = 0; dx = 0;
    for (int i = 0; i < 5; i++) evx[i] = 0;
    check_counts("R9 mid-run reset");
    record({2'd0, 12'h002, 16'd1, 3'b000, 12'h002, 16'd0, 1'b0, 1'b1}, "R9 after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule